// File: doc/BRIEF.md
# Timed Write Sequencer for a Three-Channel Parallel DAC

This controller sits on the host side of a three-channel, 8-bit, parallel-input voltage DAC. It accepts one command at a time over a valid/ready handshake. A command either loads an 8-bit code into one channel or asks the converter to power down. The controller turns each command into a bus cycle on a 2-bit address, an 8-bit data bus and an active-low write strobe. The cycle has three phases: setup, strobe-low and hold. Each phase length is derived from picosecond timing parameters and the system clock period, rounded up to whole cycles with a floor of one.

After a channel write the controller counts a settling window and then raises a `settled` flag. The converter is powered down by writing to the fourth address. The controller tracks that state. The first channel write after power-down therefore gets the longer wake-up window instead of the normal settling window. The settling count does not stall the handshake, so a new command may arrive while it runs.

Top module: `dac_wr_sequencer`

## Requirements
- R1: While reset is asserted and just after it is released, `bus_wr_n` is 1, `cmd_ready` is 1, `cmd_err` is 0 and `settled` is 1.
- R2: A channel command with `cmd_chan` 0, 1 or 2 produces exactly one strobe, with `bus_addr` equal to 2'b00, 2'b01 or 2'b10 respectively and `bus_data` equal to `cmd_code`.
- R3: Address and data are driven for exactly SU_CYC clock cycles (ceil(ADDR_SU_PS/CLK_PS), minimum 1) with the strobe high before it falls. They remain unchanged for as long as the strobe is low.
- R4: The strobe stays low for LOW_CYC cycles. LOW_CYC is the larger of ceil(WR_LOW_PS/CLK_PS) and ceil(DATA_SU_PS/CLK_PS) minus SU_CYC, with a minimum of 1.
- R5: After the strobe rises, address and data are held for HOLD_CYC cycles (ceil(HOLD_PS/CLK_PS), minimum 1). `cmd_ready` is 0 from the cycle after acceptance until that hold phase ends.
- R6: A command with `cmd_shutdown`=1 produces a strobe with `bus_addr`=2'b11 and `bus_data`=8'h00, whatever `cmd_chan` and `cmd_code` hold.
- R7: A channel command with `cmd_chan`=3 and `cmd_shutdown`=0 is accepted and causes a one-cycle `cmd_err` pulse in the next cycle. It produces no strobe and leaves `settled` unchanged.
- R8: After a normal channel write, `settled` is 0 from the cycle after acceptance. It rises exactly SETTLE_CYC cycles (ceil(SETTLE_PS/CLK_PS)) after the hold phase ends.
- R9: After a shutdown write, `settled` stays 0. The next channel write raises `settled` WAKE_CYC cycles (ceil(WAKE_PS/CLK_PS)) after its hold phase ends. Later writes use SETTLE_CYC again.
- R10: A command presented while the settling count runs is accepted at once. The settling window then restarts from the new write's hold end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_shutdown | input | 1 | 1 = power-down request, 0 = channel write |
| cmd_chan | input | 2 | Target channel for a write (0..2 valid) |
| cmd_code | input | 8 | Code to load into the channel |
| cmd_err | output | 1 | One-cycle pulse for a rejected channel number |
| bus_addr | output | 2 | Converter address bus |
| bus_data | output | 8 | Converter data bus |
| bus_wr_n | output | 1 | Converter write strobe, active low |
| settled | output | 1 | Last written channel output may be taken as stable |

## Verification
The inline properties check, on every cycle, the following: the bus is stable while the strobe is low and at its rising edge; the handshake stays closed during a strobe; an error pulse never overlaps a bus cycle; a power-down write carries zero data; the converter never reports settled while powered down; and `settled` is never high while a command is in flight. Only the bench scenarios can show the exact phase lengths in cycles, the address mapping of each channel, and the settling and wake-up windows. The same holds for the return to the short window after a wake-up, the restart of the window by a back-to-back command, and the absence of a strobe for a rejected channel.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // Round a duration up to whole clock cycles, never below one cycle.
  function automatic int unsigned to_cycles(input int unsigned dur_ps,
                                            input int unsigned clk_ps);
    int unsigned c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dacseq_phase_fsm.sv
module dacseq_phase_fsm
  import dacseq_pkg::*;
#(
  parameter int unsigned SU_CYC   = 2,
  parameter int unsigned LOW_CYC  = 5,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned CW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic wr_n,
  output logic done
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_n_q, wr_n_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(SU_CYC - 1);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_LOW;
          cnt_d   = CW'(LOW_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    wr_n_d = (phase_d != PH_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_n_q  <= wr_n_d;
    end
  end

  assign idle = (phase_q == PH_IDLE);
  assign wr_n = wr_n_q;
  assign done = (phase_q == PH_HOLD) && (cnt_q == '0);

  AST_LOW_ONLY_IN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_q |-> (phase_q == PH_LOW)) else $error("strobe low outside low phase"); // R4

endmodule

// File: rtl/dacseq_settle_tracker.sv
module dacseq_settle_tracker #(
  parameter int unsigned SETTLE_CYC = 1500,
  parameter int unsigned WAKE_CYC   = 3250,
  parameter int unsigned WW         = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic done_shut,
  output logic settled
);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          wait_q, wait_d;
  logic          asleep_q, asleep_d;
  logic          wake_q, wake_d;
  logic          settled_q, settled_d;

  always_comb begin
    cnt_d     = cnt_q;
    wait_d    = wait_q;
    asleep_d  = asleep_q;
    wake_d    = wake_q;
    settled_d = settled_q;
    if (done) begin
      settled_d = 1'b0;
      if (done_shut) begin
        asleep_d = 1'b1;
        wait_d   = 1'b0;
        wake_d   = 1'b0;
      end else begin
        cnt_d    = (asleep_q || wake_q) ? WW'(WAKE_CYC - 1) : WW'(SETTLE_CYC - 1);
        wake_d   = asleep_q || wake_q;
        asleep_d = 1'b0;
        wait_d   = 1'b1;
      end
    end else if (start) begin
      settled_d = 1'b0;
      wait_d    = 1'b0;
    end else if (wait_q) begin
      if (cnt_q == '0) begin
        settled_d = 1'b1;
        wait_d    = 1'b0;
        wake_d    = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      wait_q    <= 1'b0;
      asleep_q  <= 1'b0;
      wake_q    <= 1'b0;
      settled_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      wait_q    <= wait_d;
      asleep_q  <= asleep_d;
      wake_q    <= wake_d;
      settled_q <= settled_d;
    end
  end

  assign settled = settled_q;

  AST_ASLEEP_NOT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |-> !settled_q) else $error("settled while powered down"); // R9

endmodule

// File: rtl/dac_wr_sequencer.sv
module dac_wr_sequencer
  import dacseq_pkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned ADDR_SU_PS  = 5000,
  parameter int unsigned DATA_SU_PS  = 25000,
  parameter int unsigned WR_LOW_PS   = 20000,
  parameter int unsigned HOLD_PS     = 0,
  parameter int unsigned SETTLE_PS   = 6000000,
  parameter int unsigned WAKE_PS     = 13000000,
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_shutdown,
  input  logic [AW-1:0] cmd_chan,
  input  logic [DW-1:0] cmd_code,
  output logic          cmd_err,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_wr_n,
  output logic          settled
);

  localparam int unsigned SU_CYC     = to_cycles(ADDR_SU_PS, CLK_PS);
  localparam int unsigned DS_CYC     = to_cycles(DATA_SU_PS, CLK_PS);
  localparam int unsigned LOW_RAW    = to_cycles(WR_LOW_PS, CLK_PS);
  localparam int unsigned LOW_CYC    = (DS_CYC > SU_CYC + LOW_RAW) ? (DS_CYC - SU_CYC) : LOW_RAW;
  localparam int unsigned HOLD_CYC   = to_cycles(HOLD_PS, CLK_PS);
  localparam int unsigned SETTLE_CYC = to_cycles(SETTLE_PS, CLK_PS);
  localparam int unsigned WAKE_CYC   = to_cycles(WAKE_PS, CLK_PS);
  localparam int unsigned CW         = $clog2(max3(SU_CYC, LOW_CYC, HOLD_CYC) + 1);
  localparam int unsigned WW         = $clog2(max3(SETTLE_CYC, WAKE_CYC, 1) + 1);
  localparam logic [AW-1:0] SHUT_ADDR = {AW{1'b1}};

  logic          idle, done, accept, bad_chan, go;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          shut_q, shut_d;
  logic          err_q, err_d;

  assign accept   = cmd_valid && idle;
  assign bad_chan = !cmd_shutdown && (cmd_chan == SHUT_ADDR);
  assign go       = accept && !bad_chan;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    shut_d = shut_q;
    err_d  = accept && bad_chan;
    if (go) begin
      shut_d = cmd_shutdown;
      addr_d = cmd_shutdown ? SHUT_ADDR : cmd_chan;
      data_d = cmd_shutdown ? '0 : cmd_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      shut_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      shut_q <= shut_d;
      err_q  <= err_d;
    end
  end

  dacseq_phase_fsm #(
    .SU_CYC   (SU_CYC),
    .LOW_CYC  (LOW_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CW       (CW)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .idle  (idle),
    .wr_n  (bus_wr_n),
    .done  (done)
  );

  dacseq_settle_tracker #(
    .SETTLE_CYC (SETTLE_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .WW         (WW)
  ) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .done      (done),
    .done_shut (shut_q),
    .settled   (settled)
  );

  assign cmd_ready = idle;
  assign cmd_err   = err_q;
  assign bus_addr  = addr_q;
  assign bus_data  = data_q;

  AST_BUS_STABLE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> ($stable(bus_addr) && $stable(bus_data))) else $error("bus moved during strobe"); // R3
  AST_BUS_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> ($stable(bus_addr) && $stable(bus_data))) else $error("bus moved at strobe rise"); // R5
  AST_BUSY_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !cmd_ready) else $error("ready during strobe"); // R5
  AST_ERR_WITHOUT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> bus_wr_n) else $error("error pulse during strobe"); // R7
  AST_SHUTDOWN_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && bus_addr == SHUT_ADDR) |-> (bus_data == '0)) else $error("shutdown data not zero"); // R6
  AST_SETTLED_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> cmd_ready) else $error("settled while command in flight"); // R8

endmodule

// File: tb/dac_wr_sequencer_test.sv
module dac_wr_sequencer_test;

  localparam int CLK_PS = 4000;
  localparam int SU     = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int DSU    = (25000 + CLK_PS - 1) / CLK_PS;
  localparam int LRAW   = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int LOW    = (DSU > SU + LRAW) ? DSU - SU : LRAW;
  localparam int HOLD   = 1;
  localparam int SETTLE = (6000000 + CLK_PS - 1) / CLK_PS;
  localparam int WAKE   = (13000000 + CLK_PS - 1) / CLK_PS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_shutdown = 1'b0;
  logic [1:0] cmd_chan = 2'd0;
  logic [7:0] cmd_code = 8'd0;
  logic       cmd_ready, cmd_err, bus_wr_n, settled;
  logic [1:0] bus_addr;
  logic [7:0] bus_data;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  dac_wr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_shutdown(cmd_shutdown), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
    .cmd_err(cmd_err), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr_n(bus_wr_n), .settled(settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: pushes the expected bus write, then presents the command.
  task automatic send(input logic sd, input logic [1:0] ch, input logic [7:0] code);
    bit rej;
    rej = !sd && (ch == 2'd3);
    while (!cmd_ready) @(negedge clk);
    if (!rej) exp_q.push_back(sd ? {2'b11, 8'h00} : {ch, code});
    cmd_valid = 1'b1; cmd_shutdown = sd; cmd_chan = ch; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rej) begin
      chk(cmd_err == 1'b1, "R7 err pulse", int'(cmd_err), 1);
      chk(cmd_ready == 1'b1, "R7 ready kept", int'(cmd_ready), 1);
      @(negedge clk);
      chk(cmd_err == 1'b0, "R7 err one cycle", int'(cmd_err), 0);
    end else begin
      chk(cmd_ready == 1'b0, "R5 ready low after accept", int'(cmd_ready), 0);
      chk(settled == 1'b0, "R8 settled drops", int'(settled), 0);
    end
  endtask

  task automatic wait_settle(input int exp, input string req);
    int n;
    while (!cmd_ready) @(negedge clk);
    n = 0;
    while (!settled && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  // Monitor: measures phases and pops the scoreboard at each strobe rise.
  bit prev_wr = 1'b1;
  bit in_hold = 1'b0;
  int scnt = 0, lcnt = 0, hcnt = 0;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (prev_wr && !bus_wr_n) begin
        chk(scnt == SU, "R3 setup cycles", scnt, SU);
        scnt = 0;
        lcnt = 1;
      end else if (!prev_wr && !bus_wr_n) begin
        lcnt++;
      end else if (!prev_wr && bus_wr_n) begin
        chk(lcnt == LOW, "R4 strobe low cycles", lcnt, LOW);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected strobe", int'(bus_addr), -1);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(bus_addr == e[9:8], (e[9:8] == 2'b11) ? "R6 shutdown addr" : "R2 addr", int'(bus_addr), int'(e[9:8]));
          chk(bus_data == e[7:0], (e[9:8] == 2'b11) ? "R6 shutdown data" : "R2 data", int'(bus_data), int'(e[7:0]));
        end
        in_hold = 1'b1;
        hcnt = 1;
      end else begin
        if (in_hold) begin
          if (!cmd_ready) hcnt++;
          else begin
            chk(hcnt == HOLD, "R5 hold cycles", hcnt, HOLD);
            in_hold = 1'b0;
          end
        end else if (!cmd_ready) begin
          scnt++;
        end
      end
      prev_wr = bus_wr_n;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_wr_n == 1'b1, "R1 strobe idle in reset", int'(bus_wr_n), 1);
    chk(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_wr_n == 1'b1, "R1 strobe idle", int'(bus_wr_n), 1);
    chk(cmd_err == 1'b0, "R1 no error", int'(cmd_err), 0);
    chk(settled == 1'b1, "R1 settled after reset", int'(settled), 1);
    mon_on = 1'b1;

    send(1'b0, 2'd0, 8'h5A);
    wait_settle(SETTLE, "R8 settle window");
    send(1'b0, 2'd1, 8'hA5);
    send(1'b0, 2'd2, 8'hFF);             // R10: taken during the window
    wait_settle(SETTLE, "R10 window restarts");

    send(1'b0, 2'd3, 8'h33);              // R7: rejected channel
    repeat (12) @(negedge clk);
    chk(settled == 1'b1, "R7 settled unchanged", int'(settled), 1);
    chk(exp_q.size() == 0, "R7 no bus cycle", exp_q.size(), 0);

    send(1'b1, 2'd3, 8'h77);              // R6: chan and code ignored
    repeat (4000) @(negedge clk);
    chk(settled == 1'b0, "R9 not settled while down", int'(settled), 0);
    send(1'b0, 2'd0, 8'h00);
    wait_settle(WAKE, "R9 wake window");
    send(1'b0, 2'd2, 8'h80);
    wait_settle(SETTLE, "R9 normal window after wake");

    send(1'b1, 2'd0, 8'h12);
    send(1'b0, 2'd1, 8'h01);              // R10: accepted while down
    wait_settle(WAKE, "R9 wake after second shutdown");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule